// File: doc/BRIEF.md
# Retained Boot Vector Controller

This block chooses where a management core starts fetching after it leaves reset. It drives the core's 32-bit reset-address input and the core's reset line. It holds one "start from RAM" flag, which software sets or clears through a single Wishbone register. A hard reset clears the flag and always points the core at the base of the flash execute-in-place window (0x1000_0000). A soft reset keeps the flag. The core then restarts from local RAM at 0x0000_0000 if the flag is set, or from flash if it is clear. This lets a program that an earlier flash boot copied into RAM run again without a new copy.

The reset class is chosen when the system reset is released. At that point the block samples the shared flash data-in pin through a two-flop synchronizer: high means hard, low means soft. A power-on reset is always hard, whatever the pin level. The chosen vector is latched once per release and held while the core runs. A later change to the flag therefore acts only at the next soft reset. The class of the last reset can be read back from the register.

Top module: `boot_vector_ctrl`

## Requirements
- R1: The control register sits at byte address `CSR_ADDR` (default 0x0000_0000, low two address bits zero). Bit 0 is the RAM-boot flag. It is written from `wb_dat_i[0]` when `wb_sel_i[0]` is set and is ignored otherwise. Bit 1 reads the last reset class (1 = hard, 0 = soft). Bits 31:2 read zero. Every bus request is acknowledged with a one-cycle `wb_ack_o` pulse. Reads from any other address return zero, and writes to any other address change nothing.
- R2: A power-on reset (`por_n_i` low) always counts as hard, whatever the level of `flash_di_i`. It clears the flag, sets the vector to 0x1000_0000 and reads back class 1.
- R3: A release of `rst_n_i` with `flash_di_i` high counts as hard. It clears the flag, sets the vector to 0x1000_0000 and reads back class 1.
- R4: A release of `rst_n_i` with `flash_di_i` low and the flag set counts as soft. It gives vector 0x0000_0000, keeps the flag and reads back class 0.
- R5: A soft release with the flag clear gives vector 0x1000_0000.
- R6: The vector changes only when a reset is released. Writes to the flag, and later movement of `flash_di_i`, leave the vector and the read-back class unchanged until the next release.
- R7: `cpu_rst_n_o` is low whenever either reset input is low. It rises on the fourth rising clock edge after the reset inputs are released, one edge after the new vector appears.
- R8: While `cpu_rst_n_o` is low, bus requests are neither acknowledged nor able to change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n_i | input | 1 | System reset request, active low, asynchronous assert |
| flash_di_i | input | 1 | Shared flash data-in pin; its level at release gives the reset class |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 32 | Wishbone byte address |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_sel_i | input | 4 | Wishbone byte selects |
| wb_dat_o | output | 32 | Wishbone read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| cpu_rst_n_o | output | 1 | Reset to the core, active low |
| reset_vector_o | output | 32 | Reset address presented to the core |

## Verification
The reset sequence is run under every combination of flag state, pin level and reset source: power-on with the pin low, and system reset with the pin high or low while the flag is set and while it is clear. Comparing the vector and the read-back class across these cases separates the power-on override, the pin-driven hard path and the two soft outcomes. Flag writes between releases, pin toggles after release and byte-select-masked or off-address writes show that the vector moves only at a release. A write driven while the core is still held in reset shows that the bus is inert during that window.

// File: rtl/bvc_pkg.sv
package bvc_pkg;
  localparam int unsigned XLEN = 32;
  localparam logic [XLEN-1:0] FLASH_BASE = 32'h1000_0000;
  localparam logic [XLEN-1:0] RAM_BASE   = 32'h0000_0000;

  typedef enum logic { RST_SOFT = 1'b0, RST_HARD = 1'b1 } rst_kind_e;

  // Power-on always wins; otherwise the pin level decides.
  function automatic rst_kind_e classify(input logic por_seen, input logic pin);
    return (por_seen || pin) ? RST_HARD : RST_SOFT;
  endfunction

  function automatic logic [XLEN-1:0] pick_vector(input rst_kind_e kind,
                                                  input logic ram_en);
    return (kind == RST_SOFT && ram_en) ? RAM_BASE : FLASH_BASE;
  endfunction

  function automatic logic [XLEN-1:0] csr_word(input logic ram_en,
                                               input rst_kind_e kind);
    logic [XLEN-1:0] w;
    w    = '0;
    w[0] = ram_en;
    w[1] = (kind == RST_HARD);
    return w;
  endfunction
endpackage

// File: rtl/bvc_sync.sv
module bvc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bvc_release.sv
module bvc_release
  import bvc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      por_n_i,
  input  logic      sys_rst_n_i,
  input  logic      pin_sync_i,
  output logic      rel_pulse_o,
  output rst_kind_e rel_kind_o,
  output logic      cpu_rst_n_o,
  output logic      bus_live_o
);
  logic rst_sync;
  logic rst_seen_q;
  logic por_seen_q;
  logic cpu_q;

  bvc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (sys_rst_n_i),
    .d_i      (1'b1),
    .q_o      (rst_sync)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
    if (!sys_rst_n_i) begin
      rst_seen_q <= 1'b0;
      cpu_q      <= 1'b0;
    end else begin
      rst_seen_q <= rst_sync;
      cpu_q      <= rst_seen_q;
    end
  end

  // Remembers that the pending release follows a power-on.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)         por_seen_q <= 1'b1;
    else if (rel_pulse_o) por_seen_q <= 1'b0;
  end

  assign rel_pulse_o = rst_sync & ~rst_seen_q;
  assign rel_kind_o  = classify(por_seen_q, pin_sync_i);
  assign cpu_rst_n_o = cpu_q;
  assign bus_live_o  = cpu_q;
endmodule

// File: rtl/bvc_csr.sv
module bvc_csr
  import bvc_pkg::*;
#(
  parameter logic [XLEN-1:0] CSR_ADDR = 32'h0000_0000
) (
  input  logic            clk_i,
  input  logic            por_n_i,
  input  logic            sys_rst_n_i,
  input  logic            bus_live_i,
  input  logic            rel_pulse_i,
  input  rst_kind_e       rel_kind_i,
  input  logic            wb_cyc_i,
  input  logic            wb_stb_i,
  input  logic            wb_we_i,
  input  logic [XLEN-1:0] wb_adr_i,
  input  logic [XLEN-1:0] wb_dat_i,
  input  logic [3:0]      wb_sel_i,
  output logic [XLEN-1:0] wb_dat_o,
  output logic            wb_ack_o,
  output logic            ram_en_o,
  output rst_kind_e       last_kind_o
);
  logic            ack_q;
  logic [XLEN-1:0] rdata_q;
  logic            ram_en_q;
  rst_kind_e       kind_q;
  logic            req;
  logic            hit;
  logic            wr_en;
  logic            unused_bits;

  assign req   = bus_live_i & wb_cyc_i & wb_stb_i & ~ack_q;
  assign hit   = (wb_adr_i == CSR_ADDR);
  assign wr_en = req & wb_we_i & hit & wb_sel_i[0];
  assign unused_bits = &{1'b0, wb_dat_i[XLEN-1:1], wb_sel_i[3:1]};

  always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
    if (!sys_rst_n_i) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req;
      if (req) rdata_q <= (hit && !wb_we_i) ? csr_word(ram_en_q, kind_q) : '0;
    end
  end

  // Retained across soft resets; only power-on or a hard release clears it.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      ram_en_q <= 1'b0;
      kind_q   <= RST_HARD;
    end else if (rel_pulse_i) begin
      kind_q <= rel_kind_i;
      if (rel_kind_i == RST_HARD) ram_en_q <= 1'b0;
    end else if (wr_en) begin
      ram_en_q <= wb_dat_i[0];
    end
  end

  assign wb_ack_o    = ack_q;
  assign wb_dat_o    = rdata_q;
  assign ram_en_o    = ram_en_q;
  assign last_kind_o = kind_q;
endmodule

// File: rtl/bvc_vec_hold.sv
module bvc_vec_hold
  import bvc_pkg::*;
(
  input  logic            clk_i,
  input  logic            por_n_i,
  input  logic            rel_pulse_i,
  input  rst_kind_e       rel_kind_i,
  input  logic            ram_en_i,
  output logic [XLEN-1:0] vector_o
);
  logic [XLEN-1:0] vec_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)         vec_q <= FLASH_BASE;
    else if (rel_pulse_i) vec_q <= pick_vector(rel_kind_i, ram_en_i);
  end

  assign vector_o = vec_q;
endmodule

// File: rtl/boot_vector_ctrl.sv
module boot_vector_ctrl
  import bvc_pkg::*;
#(
  parameter logic [31:0] CSR_ADDR    = 32'h0000_0000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        por_n_i,
  input  logic        rst_n_i,
  input  logic        flash_di_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [31:0] wb_adr_i,
  input  logic [31:0] wb_dat_i,
  input  logic [3:0]  wb_sel_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic        cpu_rst_n_o,
  output logic [31:0] reset_vector_o
);
  logic      sys_rst_n;
  logic      pin_sync;
  logic      rel_pulse;
  rst_kind_e rel_kind;
  logic      rel_hard;
  logic      bus_live;
  logic      boot_en;
  rst_kind_e last_kind;

  assign sys_rst_n = por_n_i & rst_n_i;
  assign rel_hard  = (rel_kind == RST_HARD);

  bvc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_n_i),
    .d_i      (flash_di_i),
    .q_o      (pin_sync)
  );

  bvc_release #(.SYNC_STAGES(SYNC_STAGES)) u_release (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .sys_rst_n_i (sys_rst_n),
    .pin_sync_i  (pin_sync),
    .rel_pulse_o (rel_pulse),
    .rel_kind_o  (rel_kind),
    .cpu_rst_n_o (cpu_rst_n_o),
    .bus_live_o  (bus_live)
  );

  bvc_csr #(.CSR_ADDR(CSR_ADDR)) u_csr (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .sys_rst_n_i (sys_rst_n),
    .bus_live_i  (bus_live),
    .rel_pulse_i (rel_pulse),
    .rel_kind_i  (rel_kind),
    .wb_cyc_i    (wb_cyc_i),
    .wb_stb_i    (wb_stb_i),
    .wb_we_i     (wb_we_i),
    .wb_adr_i    (wb_adr_i),
    .wb_dat_i    (wb_dat_i),
    .wb_sel_i    (wb_sel_i),
    .wb_dat_o    (wb_dat_o),
    .wb_ack_o    (wb_ack_o),
    .ram_en_o    (boot_en),
    .last_kind_o (last_kind)
  );

  bvc_vec_hold u_vec (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .rel_pulse_i (rel_pulse),
    .rel_kind_i  (rel_kind),
    .ram_en_i    (boot_en),
    .vector_o    (reset_vector_o)
  );
endmodule

// File: rtl/bvc_chk.sv
module bvc_chk (
  input logic        clk_i,
  input logic        por_n_i,
  input logic        rst_n_i,
  input logic        rel_pulse,
  input logic        rel_hard,
  input logic        boot_en,
  input logic        cpu_rst_n_o,
  input logic        wb_ack_o,
  input logic [31:0] wb_dat_o,
  input logic [31:0] reset_vector_o
);
  AST_HARD_TO_FLASH: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (rel_pulse && rel_hard) |=> (reset_vector_o == 32'h1000_0000 && !boot_en)); // R3

  AST_SOFT_PICK: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (rel_pulse && !rel_hard) |=>
      (reset_vector_o == ($past(boot_en) ? 32'h0000_0000 : 32'h1000_0000))); // R4

  AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !rel_pulse |=> $stable(reset_vector_o)); // R6

  AST_CPU_HELD: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !rst_n_i |-> !cpu_rst_n_o); // R7

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wb_ack_o |=> !wb_ack_o); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wb_ack_o |-> (wb_dat_o[31:2] == 30'd0)); // R1

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !cpu_rst_n_o |-> !wb_ack_o); // R8
endmodule

bind boot_vector_ctrl bvc_chk chk_i (
  .clk_i          (clk_i),
  .por_n_i        (por_n_i),
  .rst_n_i        (rst_n_i),
  .rel_pulse      (rel_pulse),
  .rel_hard       (rel_hard),
  .boot_en        (boot_en),
  .cpu_rst_n_o    (cpu_rst_n_o),
  .wb_ack_o       (wb_ack_o),
  .wb_dat_o       (wb_dat_o),
  .reset_vector_o (reset_vector_o)
);

// File: tb/boot_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_vector_ctrl_tb_top;
  localparam logic [31:0] FLASH = 32'h1000_0000;
  localparam logic [31:0] RAM   = 32'h0000_0000;
  localparam logic [31:0] CSR   = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0, flash_di = 1'b0;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [31:0] wb_adr = '0, wb_dat = '0;
  logic [3:0]  wb_sel = '0;
  logic [31:0] wb_dat_o, reset_vector;
  logic        wb_ack, cpu_rst_n;

  int tests = 0, fails = 0;
  bit done = 0;

  // Model state kept by the bench.
  bit m_en = 0, m_hard = 1;

  typedef struct { bit is_rd; logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  boot_vector_ctrl dut_i (
    .clk_i (clk), .por_n_i (por_n), .rst_n_i (rst_n), .flash_di_i (flash_di),
    .wb_cyc_i (wb_cyc), .wb_stb_i (wb_stb), .wb_we_i (wb_we),
    .wb_adr_i (wb_adr), .wb_dat_i (wb_dat), .wb_sel_i (wb_sel),
    .wb_dat_o (wb_dat_o), .wb_ack_o (wb_ack),
    .cpu_rst_n_o (cpu_rst_n), .reset_vector_o (reset_vector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {30'd0, m_hard, m_en};
  endfunction

  // Monitor: pops one scoreboard item per acknowledge.
  always @(negedge clk) begin
    if (wb_ack) begin
      if (sb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8: actual unexpected ack expected none");
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.is_rd) check(it.tag, wb_dat_o, it.exp);
      end
    end
  end

  task automatic wb_xfer(input bit we, input logic [31:0] adr, input logic [31:0] dat,
                         input logic [3:0] sel, input logic [31:0] exp, input string tag);
    bit got;
    sb_item_t it;
    it.is_rd = !we; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat = dat; wb_sel = sel;
    got = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wb_ack) begin got = 1; break; end
    end
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    check({tag, " ack"}, {31'd0, got}, 32'd1);
  endtask

  task automatic rd_csr(input string tag);
    wb_xfer(0, CSR, '0, 4'hF, exp_word(), tag);
  endtask

  task automatic wr_en(input bit v);
    wb_xfer(1, CSR, {31'd0, v}, 4'h1, '0, "R1 write");
    m_en = v;
  endtask

  // One full reset cycle; poke drives a write while the core is held.
  task automatic reset_cycle(input bit por, input bit pin, input bit poke, input string tag);
    logic [31:0] exp_vec;
    @(negedge clk);
    flash_di = pin;
    if (por) por_n = 0; else rst_n = 0;
    @(negedge clk);
    check({tag, " R7 held"}, {31'd0, cpu_rst_n}, 32'd0);
    if (poke) begin
      wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = CSR; wb_dat = 32'd1; wb_sel = 4'h1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check("R8 no ack in reset", {31'd0, wb_ack}, 32'd0);
      end
      wb_cyc = 0; wb_stb = 0; wb_we = 0;
    end
    repeat (4) @(negedge clk);
    por_n = 1; rst_n = 1;
    m_hard = por | pin;
    if (m_hard) m_en = 0;
    exp_vec = (!m_hard && m_en) ? RAM : FLASH;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tag, " R7 still held"}, {31'd0, cpu_rst_n}, 32'd0);
    check({tag, " vector"}, reset_vector, exp_vec);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R7 released"}, {31'd0, cpu_rst_n}, 32'd1);
    flash_di = ~pin;
    repeat (4) @(negedge clk);
    check({tag, " R6 pin after release"}, reset_vector, exp_vec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset vector under por", reset_vector, FLASH);
    check("R7 cpu held under por", {31'd0, cpu_rst_n}, 32'd0);
    reset_cycle(1, 0, 0, "R2 por pin low");
    rd_csr("R2 csr after por");

    wr_en(1);
    rd_csr("R1 readback en");
    check("R6 vector after write", reset_vector, FLASH);
    wb_xfer(0, 32'h0000_0010, '0, 4'hF, 32'd0, "R1 other addr read");
    wb_xfer(1, 32'h0000_0010, 32'd0, 4'hF, '0, "R1 other addr write");
    wb_xfer(1, CSR, 32'd0, 4'hE, '0, "R1 masked write");
    rd_csr("R1 ignored writes");

    reset_cycle(0, 0, 0, "R4 soft en set");
    rd_csr("R4 csr soft");

    wr_en(0);
    check("R6 vector kept after clear", reset_vector, RAM);
    rd_csr("R6 csr after clear");
    reset_cycle(0, 0, 0, "R5 soft en clear");
    rd_csr("R5 csr");

    wr_en(1);
    reset_cycle(0, 1, 0, "R3 hard pin high");
    rd_csr("R3 csr");

    wr_en(1);
    reset_cycle(1, 0, 0, "R2 por clears en");
    rd_csr("R2 csr");

    reset_cycle(0, 0, 1, "R8 soft with poke");
    rd_csr("R8 en unchanged");

    wr_en(1);
    reset_cycle(0, 0, 0, "R4 soft again");
    rd_csr("R4 csr again");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule